// File: doc/BRIEF.md
# Debug Monitor Entry Controller

This block decides, each time the external reset pin is released, whether a small 8-bit controller core starts in debug monitor mode or in normal user mode. A high-voltage detect flag and four strap pin levels pass through two-flop synchronizers. They are latched once, on the cycle the synchronized reset pin is seen rising. The latched result drives the mode flag, the oscillator divide-by-two bypass select and a burn-in jump-to-RAM request. A software-interrupt strobe can also move a running core into monitor mode.

While monitor mode is active, vector fetches are redirected from the top address page (high byte 0xFF) to the page below it (0xFE). The watchdog enable is held low for as long as either high-voltage flag is present. On every entry into monitor mode a break character is sent on the serial line: ten low bit periods timed by an external bit-rate tick, then one high stop period, then a one-cycle done pulse. The host uses the break as a ready signal and as a bit-rate reference.

Top module: `monitor_entry_ctrl`

## Requirements
- R1: While `rst` is high and after it falls with `rst_pin_n` low, the outputs are: `mon_mode`=0, `clk_bypass`=0, `burnin_req`=0, `cop_en`=1, `ser_tx`=1 and `brk_done`=0.
- R2: A low-then-high pulse on `rst_pin_n` is a release. After synchronization, a release selects monitor mode only when `hv_irq`=1, `strap_en_a`=1 and `strap_en_b`=0. Any other combination selects user mode.
- R3: `clk_bypass` is 1 only when a release selected monitor mode while `strap_div_n` was 0. It is 0 in user mode.
- R4: `burnin_req` is 1 only when a release selected monitor mode while `strap_burn_n` was 0.
- R5: Strap and high-voltage levels that change after a release do not change `mon_mode`, `clk_bypass` or `burnin_req` before the next release.
- R6: A `swi_evt` pulse while running in user mode sets `mon_mode`, leaves `burnin_req` at 0 and `clk_bypass` unchanged, and starts a break.
- R7: `vec_addr` = {page, low byte}. The page is 0xFE when `vec_fetch`=1 and `mon_mode`=1, and 0xFF otherwise. The low byte is 0xFC for `vec_kind` 1 (break) and 2 (software interrupt), and 0xFE for 0 (reset) and 3. `vec_low`=1 adds 1 to the low byte.
- R8: `cop_en` is 0 while `mon_mode`=1 and either `hv_irq` or `hv_rst` is present after synchronization. It returns to 1 within four cycles of both flags going low. The mode stays monitor.
- R9: On monitor entry `ser_tx` goes low in the same cycle that the break starts. It stays low until the tenth `bit_tick` and is high in the cycle after that tick.
- R10: `brk_done` is a single-cycle pulse in the cycle after the eleventh `bit_tick` of a break. `ser_tx` stays high from then on.
- R11: A `swi_evt` in the same cycle as a detected release is ignored. The strap decision alone sets the mode, the bypass select, the burn-in request and the break.
- R12: A `swi_evt` in monitor mode restarts the break from its first low bit.
- R13: While the synchronized `rst_pin_n` is low, `mon_mode`, `clk_bypass` and `burnin_req` are 0, `ser_tx` is 1, and `bit_tick` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high system reset |
| rst_pin_n | input | 1 | External reset pin level, asynchronous, low asserts |
| swi_evt | input | 1 | Software-interrupt strobe from the core, one cycle |
| hv_irq | input | 1 | High voltage detected on the interrupt pin |
| hv_rst | input | 1 | High voltage detected on the reset pin |
| strap_en_a | input | 1 | Entry strap, must be 1 for monitor mode |
| strap_en_b | input | 1 | Entry strap, must be 0 for monitor mode |
| strap_burn_n | input | 1 | 0 requests the burn-in jump to RAM in monitor mode |
| strap_div_n | input | 1 | 0 bypasses the oscillator divide-by-two in monitor mode |
| bit_tick | input | 1 | One-cycle strobe per serial bit period |
| vec_fetch | input | 1 | Core is fetching an interrupt or reset vector |
| vec_kind | input | 2 | Vector kind: 0 reset, 1 break, 2 software interrupt, 3 treated as reset |
| vec_low | input | 1 | 1 selects the low byte of the vector pair |
| mon_mode | output | 1 | 1 in monitor mode |
| vec_addr | output | 16 | Vector fetch address |
| cop_en | output | 1 | Watchdog enable |
| clk_bypass | output | 1 | Oscillator divider bypass select |
| burnin_req | output | 1 | Burn-in jump-to-RAM request |
| ser_tx | output | 1 | Serial transmit line, idles high |
| brk_done | output | 1 | One-cycle pulse when the break character has finished |

## Verification
Two functions can act on the same edge: strap latching at the reset release, and software-interrupt entry. The bench raises `rst_pin_n` and places the `swi_evt` pulse in exactly the cycle where the synchronized release is detected. It judges the outcome by the mode, the burn-in request and the serial line. With user straps, the mode must stay user and the line idle. With monitor straps that request burn-in, the request must survive, because an interrupt entry would have cleared it. A second collision, a software interrupt arriving partway through a break, is judged by counting ticks until the line returns high.

// File: rtl/monent_pkg.sv
package monent_pkg;

  typedef enum logic [1:0] {
    VK_RESET = 2'd0,
    VK_BREAK = 2'd1,
    VK_SWI   = 2'd2,
    VK_SPARE = 2'd3
  } vec_kind_t;

  typedef enum logic [1:0] {
    TX_IDLE = 2'd0,
    TX_BRK  = 2'd1,
    TX_STOP = 2'd2
  } tx_state_t;

  // synchronized pin bundle
  typedef struct packed {
    logic rst_pin;
    logic hv_irq;
    logic hv_rst;
    logic en_a;
    logic en_b;
    logic burn_n;
    logic div_n;
  } pins_t;

endpackage

// File: rtl/monent_sync.sv
module monent_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  localparam int NS = (STAGES < 2) ? 2 : STAGES;

  logic [NS-1:0][W-1:0] stg;

  always_ff @(posedge clk) begin
    if (rst) stg <= '0;
    else     stg <= {stg[NS-2:0], d};
  end

  assign q = stg[NS-1];
endmodule

// File: rtl/monent_mode.sv
module monent_mode
  import monent_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  pins_t pins,
  input  logic  swi_evt,
  output logic  mon_o,
  output logic  bypass_o,
  output logic  burnin_o,
  output logic  cop_en_o,
  output logic  start_brk_o,
  output logic  hold_o
);
  logic rst_d;
  logic mon_q, byp_q, burn_q, cop_q;
  logic mon_n, byp_n, burn_d;
  logic rel, entry, start;

  always_comb begin
    rel    = pins.rst_pin & ~rst_d;
    entry  = pins.hv_irq & pins.en_a & ~pins.en_b;
    mon_n  = mon_q;
    byp_n  = byp_q;
    burn_d = burn_q;
    start  = 1'b0;
    if (!pins.rst_pin) begin
      mon_n  = 1'b0;
      byp_n  = 1'b0;
      burn_d = 1'b0;
    end else if (rel) begin
      // release decision has priority over a coincident interrupt
      mon_n  = entry;
      byp_n  = entry & ~pins.div_n;
      burn_d = entry & ~pins.burn_n;
      start  = entry;
    end else if (swi_evt) begin
      mon_n  = 1'b1;
      burn_d = 1'b0;
      start  = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rst_d  <= 1'b0;
      mon_q  <= 1'b0;
      byp_q  <= 1'b0;
      burn_q <= 1'b0;
      cop_q  <= 1'b1;
    end else begin
      rst_d  <= pins.rst_pin;
      mon_q  <= mon_n;
      byp_q  <= byp_n;
      burn_q <= burn_d;
      cop_q  <= !(mon_n && (pins.hv_irq || pins.hv_rst));
    end
  end

  assign mon_o       = mon_q;
  assign bypass_o    = byp_q;
  assign burnin_o    = burn_q;
  assign cop_en_o    = cop_q;
  assign start_brk_o = start;
  assign hold_o      = ~pins.rst_pin;

  assert_burnin_in_monitor_R4: assert property (@(posedge clk) disable iff (rst)
    burn_q |-> mon_q);
  assert_bypass_in_monitor_R3: assert property (@(posedge clk) disable iff (rst)
    byp_q |-> mon_q);
  assert_pin_low_clears_R13: assert property (@(posedge clk) disable iff (rst)
    !pins.rst_pin |=> (!mon_q && !burn_q));
  assert_cop_back_without_hv_R8: assert property (@(posedge clk) disable iff (rst)
    (!pins.hv_irq && !pins.hv_rst) |=> cop_q);
endmodule

// File: rtl/monent_vec.sv
module monent_vec
  import monent_pkg::*;
#(
  parameter int              ADDR_W   = 16,
  parameter logic [ADDR_W/2-1:0] USR_PAGE = 8'hFF,
  parameter logic [ADDR_W/2-1:0] MON_PAGE = 8'hFE,
  parameter logic [ADDR_W/2-1:0] RST_LO   = 8'hFE,
  parameter logic [ADDR_W/2-1:0] INT_LO   = 8'hFC
) (
  input  logic              mon,
  input  logic              vec_fetch,
  input  vec_kind_t         kind,
  input  logic              low,
  output logic [ADDR_W-1:0] addr
);
  localparam int BW = ADDR_W / 2;

  logic [BW-1:0] page, lo;

  always_comb begin
    page = (vec_fetch && mon) ? MON_PAGE : USR_PAGE;
    case (kind)
      VK_BREAK, VK_SWI: lo = INT_LO;
      default:          lo = RST_LO;
    endcase
    lo = lo | {{(BW-1){1'b0}}, low};
    addr = {page, lo};
  end
endmodule

// File: rtl/monent_brk_tx.sv
module monent_brk_tx
  import monent_pkg::*;
#(
  parameter int BRK_BITS  = 10,
  parameter int STOP_BITS = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic hold,
  input  logic start,
  input  logic tick,
  output logic ser_tx,
  output logic done
);
  localparam int CNT_MAX = (BRK_BITS > STOP_BITS) ? BRK_BITS : STOP_BITS;
  localparam int CW      = $clog2(CNT_MAX + 1);

  tx_state_t     state;
  logic [CW-1:0] cnt;
  logic          done_q;

  always_ff @(posedge clk) begin
    if (rst || hold) begin
      state  <= TX_IDLE;
      cnt    <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start) begin
        state <= TX_BRK;
        cnt   <= '0;
      end else begin
        case (state)
          TX_BRK: if (tick) begin
            if (cnt == CW'(BRK_BITS - 1)) begin
              state <= TX_STOP;
              cnt   <= '0;
            end else cnt <= cnt + 1'b1;
          end
          TX_STOP: if (tick) begin
            if (cnt == CW'(STOP_BITS - 1)) begin
              state  <= TX_IDLE;
              cnt    <= '0;
              done_q <= 1'b1;
            end else cnt <= cnt + 1'b1;
          end
          default: cnt <= '0;
        endcase
      end
    end
  end

  assign ser_tx = (state != TX_BRK);
  assign done   = done_q;

  assert_cnt_in_range_R9: assert property (@(posedge clk) disable iff (rst)
    cnt < CW'(CNT_MAX));
  assert_low_after_start_R9: assert property (@(posedge clk) disable iff (rst)
    (start && !hold) |=> !ser_tx);
  assert_done_single_R10: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  assert_done_line_high_R10: assert property (@(posedge clk) disable iff (rst)
    done |-> ser_tx);
endmodule

// File: rtl/monitor_entry_ctrl.sv
module monitor_entry_ctrl
  import monent_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int BRK_BITS    = 10,
  parameter int STOP_BITS   = 1,
  parameter int ADDR_W      = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rst_pin_n,
  input  logic              swi_evt,
  input  logic              hv_irq,
  input  logic              hv_rst,
  input  logic              strap_en_a,
  input  logic              strap_en_b,
  input  logic              strap_burn_n,
  input  logic              strap_div_n,
  input  logic              bit_tick,
  input  logic              vec_fetch,
  input  logic [1:0]        vec_kind,
  input  logic              vec_low,
  output logic              mon_mode,
  output logic [ADDR_W-1:0] vec_addr,
  output logic              cop_en,
  output logic              clk_bypass,
  output logic              burnin_req,
  output logic              ser_tx,
  output logic              brk_done
);
  localparam int PW = $bits(pins_t);

  pins_t pins_raw, pins_s;
  logic  start_brk, hold;

  assign pins_raw = '{rst_pin: rst_pin_n, hv_irq: hv_irq, hv_rst: hv_rst,
                      en_a: strap_en_a, en_b: strap_en_b,
                      burn_n: strap_burn_n, div_n: strap_div_n};

  monent_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (pins_raw),
    .q   (pins_s)
  );

  monent_mode u_mode (
    .clk         (clk),
    .rst         (rst),
    .pins        (pins_s),
    .swi_evt     (swi_evt),
    .mon_o       (mon_mode),
    .bypass_o    (clk_bypass),
    .burnin_o    (burnin_req),
    .cop_en_o    (cop_en),
    .start_brk_o (start_brk),
    .hold_o      (hold)
  );

  monent_vec #(.ADDR_W(ADDR_W)) u_vec (
    .mon       (mon_mode),
    .vec_fetch (vec_fetch),
    .kind      (vec_kind_t'(vec_kind)),
    .low       (vec_low),
    .addr      (vec_addr)
  );

  monent_brk_tx #(.BRK_BITS(BRK_BITS), .STOP_BITS(STOP_BITS)) u_tx (
    .clk    (clk),
    .rst    (rst),
    .hold   (hold),
    .start  (start_brk),
    .tick   (bit_tick),
    .ser_tx (ser_tx),
    .done   (brk_done)
  );

  assert_user_page_R7: assert property (@(posedge clk) disable iff (rst)
    !mon_mode |-> (vec_addr[ADDR_W-1:ADDR_W/2] == {(ADDR_W/2){1'b1}}));
endmodule

// File: tb/sim_monitor_entry_ctrl.sv
`timescale 1ns/1ps
module sim_monitor_entry_ctrl;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rst_pin_n = 1'b0, swi_evt = 1'b0, hv_irq = 1'b0, hv_rst = 1'b0;
  logic strap_en_a = 1'b0, strap_en_b = 1'b0, strap_burn_n = 1'b1, strap_div_n = 1'b1;
  logic bit_tick = 1'b0, vec_fetch = 1'b0, vec_low = 1'b0;
  logic [1:0] vec_kind = 2'd0;
  logic mon_mode, cop_en, clk_bypass, burnin_req, ser_tx, brk_done;
  logic [15:0] vec_addr;
  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  monitor_entry_ctrl u0 (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic set_straps(input logic hv, input logic a, input logic b,
                            input logic bn, input logic dn);
    hv_irq = hv; strap_en_a = a; strap_en_b = b; strap_burn_n = bn; strap_div_n = dn;
  endtask

  task automatic do_reset(input logic hv, input logic a, input logic b,
                          input logic bn, input logic dn);
    @(negedge clk);
    rst_pin_n = 1'b0;
    set_straps(hv, a, b, bn, dn);
    repeat (4) @(negedge clk);
    rst_pin_n = 1'b1;
    repeat (5) @(negedge clk);
  endtask

  task automatic tick_once();
    bit_tick = 1'b1;
    @(negedge clk);
    bit_tick = 1'b0;
  endtask

  task automatic swi_pulse();
    swi_evt = 1'b1;
    @(negedge clk);
    swi_evt = 1'b0;
  endtask

  initial begin
    #4_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    // R1: reset state
    check("R1 mon", mon_mode, 0);
    check("R1 bypass", clk_bypass, 0);
    check("R1 burnin", burnin_req, 0);
    check("R1 cop", cop_en, 1);
    check("R1 tx", ser_tx, 1);
    check("R1 done", brk_done, 0);
    vec_fetch = 1'b1; #1;
    check("R1 vec", vec_addr, 16'hFFFE);
    vec_fetch = 1'b0;

    // R2 R3 R4 R7 R8: exhaustive strap sweep with every vector combination
    for (int i = 0; i < 32; i++) begin
      logic em, eb, ebn;
      do_reset(i[4], i[3], i[2], i[1], i[0]);
      em  = i[4] & i[3] & ~i[2];
      eb  = em & ~i[0];
      ebn = em & ~i[1];
      check("R2 mode", mon_mode, em);
      check("R3 bypass", clk_bypass, eb);
      check("R4 burnin", burnin_req, ebn);
      check("R8 cop", cop_en, !em);
      check("R9 tx", ser_tx, !em);
      for (int f = 0; f < 2; f++)
        for (int k = 0; k < 4; k++)
          for (int l = 0; l < 2; l++) begin
            logic [15:0] ev;
            ev[15:8] = (f == 1 && em) ? 8'hFE : 8'hFF;
            ev[7:0]  = ((k == 1 || k == 2) ? 8'hFC : 8'hFE) + 8'(l);
            vec_fetch = f[0]; vec_kind = k[1:0]; vec_low = l[0];
            #1;
            check("R7 vec", vec_addr, ev);
          end
      vec_fetch = 1'b0;
    end

    // R5: straps changed after release are ignored
    do_reset(1, 1, 0, 0, 0);
    set_straps(0, 0, 1, 1, 1);
    repeat (6) @(negedge clk);
    check("R5 mon", mon_mode, 1);
    check("R5 bypass", clk_bypass, 1);
    check("R5 burnin", burnin_req, 1);

    // R8: watchdog held off by either high-voltage flag
    do_reset(1, 1, 0, 1, 1);
    check("R8 cop off", cop_en, 0);
    hv_irq = 1'b0; hv_rst = 1'b1;
    repeat (4) @(negedge clk);
    check("R8 cop off rst hv", cop_en, 0);
    hv_rst = 1'b0;
    repeat (4) @(negedge clk);
    check("R8 cop back", cop_en, 1);
    check("R8 mode kept", mon_mode, 1);

    // R9 R10: break timing
    do_reset(1, 1, 0, 1, 1);
    check("R9 low at entry", ser_tx, 0);
    for (int t = 0; t < 9; t++) tick_once();
    check("R9 low after 9", ser_tx, 0);
    tick_once();
    check("R9 high after 10", ser_tx, 1);
    check("R10 no done yet", brk_done, 0);
    tick_once();
    check("R10 done", brk_done, 1);
    check("R10 line high", ser_tx, 1);
    @(negedge clk);
    check("R10 done single", brk_done, 0);

    // R12: interrupt in monitor restarts break
    do_reset(1, 1, 0, 1, 1);
    for (int t = 0; t < 5; t++) tick_once();
    swi_pulse();
    for (int t = 0; t < 9; t++) tick_once();
    check("R12 still low", ser_tx, 0);
    tick_once();
    check("R12 high after restart", ser_tx, 1);

    // R6: interrupt entry from user mode
    do_reset(0, 1, 0, 0, 0);
    check("R6 user first", mon_mode, 0);
    swi_pulse();
    check("R6 mon", mon_mode, 1);
    check("R6 tx low", ser_tx, 0);
    check("R6 burnin", burnin_req, 0);
    check("R6 bypass", clk_bypass, 0);
    check("R8 cop no hv", cop_en, 1);

    // R11: interrupt coincident with release, user straps
    @(negedge clk);
    rst_pin_n = 1'b0; set_straps(0, 0, 0, 1, 1);
    repeat (4) @(negedge clk);
    rst_pin_n = 1'b1;
    @(negedge clk); @(negedge clk);
    swi_pulse();
    repeat (3) @(negedge clk);
    check("R11 user kept", mon_mode, 0);
    check("R11 line idle", ser_tx, 1);
    // R11: coincident with release, monitor + burn-in straps
    rst_pin_n = 1'b0; set_straps(1, 1, 0, 0, 1);
    repeat (4) @(negedge clk);
    rst_pin_n = 1'b1;
    @(negedge clk); @(negedge clk);
    swi_pulse();
    repeat (3) @(negedge clk);
    check("R11 mon", mon_mode, 1);
    check("R11 burnin kept", burnin_req, 1);

    // R13: pin low clears mode, idles line, ignores ticks
    do_reset(1, 1, 0, 0, 0);
    rst_pin_n = 1'b0;
    repeat (4) @(negedge clk);
    check("R13 mon", mon_mode, 0);
    check("R13 bypass", clk_bypass, 0);
    check("R13 burnin", burnin_req, 0);
    check("R13 tx", ser_tx, 1);
    for (int t = 0; t < 12; t++) tick_once();
    check("R13 done", brk_done, 0);
    check("R13 tx after ticks", ser_tx, 1);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule